// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the device side of a parallel NOR flash emulator whose array lives in an internal RAM. The host issues single-cycle bus writes (address plus data, strobed by `wr_en`). The block decodes them into command sequences: unlock, single-word program, bypass program, buffered program, sector erase, identifier query and reset. It then carries out the resulting array update over a timed busy window.

While an update runs, reads return a status word instead of array contents, and `rdy` is held low. Bit 7 of the status word is a polarity flag. Bit 6 flips on every status read. A per-sector lock vector and a write-protect pin veto updates to the sectors they cover. A vetoed command costs a single busy cycle and leaves the array unchanged.

The word address is `ADDR_W` bits wide. The top `SECT_W` bits select a uniform sector. With the defaults there are 8 sectors of 256 words, and the sector number is `addr[10:8]`. Unlock cycles compare only the low 11 address bits and the low data byte.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `rdy` is 1 and a read (`rd_en`) returns the array word at `addr` on `rdata` one clock later. The array powers up at FFFFh.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then data@address stores that data word at that address once the busy window ends.
- R3: A program holds `rdy` low for exactly `BUSY_CYC` cycles, starting the cycle after the last write. During that window a read returns 0 in bits 15..8 and 5..0. Bit 7 is the complement of bit 7 of the last word being programmed, and 0 during an erase. Bit 6 differs between any two consecutive status reads.
- R4: Unlock followed by 20h@555h enters bypass mode. In bypass mode a program is two writes: A0h at any address, then data@address. The writes 90h then 00h leave bypass mode and return to array reading.
- R5: Buffered program is an unlock, then 25h@SA, then N-1@SA (N-1 from 0 to 15, upper bits of the data zero), then N data writes inside sector SA, then 29h@SA. This programs all N words. A count value above 15 aborts to array reading.
- R6: The sequence unlock, 80h@555h, unlock, 30h@SA erases every word of sector SA to FFFFh and leaves other sectors unchanged. It holds `rdy` low for one cycle per sector word.
- R7: Unlock followed by 90h@555h enters identifier mode, selected by `addr[1:0]`. A value of 0 reads `MFR_ID`, 1 reads `DEV_ID`, and 2 reads 0001h if the addressed sector is protected and 0000h otherwise. F0h returns the block to array reading.
- R8: A sector is protected when its `sect_lock` bit is 1, or when `wp_n` is 0 and it is the last sector (`WP_LAST`=1). A program or erase to a protected sector holds `rdy` low for one cycle and changes no array word.
- R9: A write that does not match the next expected step of an unlock sequence aborts to array reading. Subsequent plain writes do not change the array.
- R10: `rst_n` low aborts any operation and forces `rdy` high. Writes made while `rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect for the boundary sector, active low |
| sect_lock | input | 2**SECT_W | Per-sector protection flags |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| rdy | output | 1 | High when no program or erase is running |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a single-cycle strobe.
- `sect_lock` and `wp_n` do not change while a command sequence is being entered.
- Buffered-program data writes stay inside the announced sector.

The stimulus enters each write through a task that pulses `wr_en` for one cycle. It changes `sect_lock` and `wp_n` only while the block is in array or identifier mode. It places buffered data only in the sector named by the 25h write. Busy windows are measured from the negative edge after the final write, so the expected durations and status bits follow directly from the requirements.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 3,
  parameter int BUSY_CYC = 20,
  parameter int WP_LAST = 1,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h7E
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n,
  input  logic [2**SECT_W-1:0]   sect_lock,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [15:0]            wdata,
  output logic [15:0]            rdata,
  output logic                   rdy
);
  localparam int WORDS = 2**ADDR_W;
  localparam int NSECT = 2**SECT_W;
  localparam int OFF_W = ADDR_W - SECT_W;
  localparam int SECT_WORDS = 2**OFF_W;
  localparam int CNT_MAX = (SECT_WORDS > BUSY_CYC) ? SECT_WORDS : BUSY_CYC;
  localparam int CNT_W = $clog2(CNT_MAX) + 1;
  localparam int WP_SECT = WP_LAST ? NSECT - 1 : 0;

  typedef enum logic [3:0] {S_READ, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3, S_AUTO,
                            S_BYP, S_BYPP, S_BYPX, S_WBC, S_WBD, S_WBF, S_BUSY} st_t;

  st_t st;
  logic [15:0] mem [WORDS];
  logic [ADDR_W-1:0] buf_a [16];
  logic [15:0] buf_d [16];
  logic [CNT_W-1:0] cnt, endc;
  logic [3:0] last, wb_i;
  logic [SECT_W-1:0] wsect;
  logic is_er, blocked, ret_byp, tog;

  wire [7:0] d = wdata[7:0];
  wire at555 = addr[10:0] == 11'h555;
  wire at2aa = addr[10:0] == 11'h2AA;
  wire [SECT_W-1:0] sa = addr[ADDR_W-1 -: SECT_W];
  wire [NSECT-1:0] prot_v = sect_lock | ({NSECT{~wp_n}} & (NSECT'(1) << WP_SECT));

  wire go_prog = wr_en && (st == S_PROG || st == S_BYPP);
  wire go_er = wr_en && st == S_E3 && d == 8'h30;
  wire go_wb = wr_en && st == S_WBF && d == 8'h29 && sa == wsect;
  wire launch = go_prog || go_er || go_wb;
  wire [SECT_W-1:0] l_sect = go_wb ? wsect : sa;
  wire mem_we = st == S_BUSY && !blocked && (is_er || cnt <= CNT_W'(last));
  wire [ADDR_W-1:0] waddr = is_er ? {wsect, cnt[OFF_W-1:0]} : buf_a[cnt[3:0]];

  assign rdy = st != S_BUSY;

  initial for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= is_er ? 16'hFFFF : buf_d[cnt[3:0]];
    if (go_prog) begin
      buf_a[0] <= addr;
      buf_d[0] <= wdata;
    end
    if (wr_en && st == S_WBD && sa == wsect) begin
      buf_a[wb_i] <= addr;
      buf_d[wb_i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READ; cnt <= '0; endc <= '0; last <= '0; wb_i <= '0;
      wsect <= '0; is_er <= 1'b0; blocked <= 1'b0; ret_byp <= 1'b0;
    end else if (launch) begin
      st <= S_BUSY;
      cnt <= '0;
      is_er <= go_er;
      blocked <= prot_v[l_sect];
      wsect <= l_sect;
      if (go_prog) last <= '0;
      endc <= prot_v[l_sect] ? '0 : go_er ? CNT_W'(SECT_WORDS - 1) : CNT_W'(BUSY_CYC - 1);
    end else if (st == S_BUSY) begin
      if (cnt == endc) st <= ret_byp ? S_BYP : S_READ;
      else cnt <= cnt + 1'b1;
    end else if (wr_en) begin
      case (st)
        S_READ: if (d == 8'hAA && at555) st <= S_U1;
        S_U1:   st <= (d == 8'h55 && at2aa) ? S_U2 : S_READ;
        S_U2:
          if (d == 8'h25) begin st <= S_WBC; wsect <= sa; end
          else if (at555 && d == 8'hA0) st <= S_PROG;
          else if (at555 && d == 8'h80) st <= S_E1;
          else if (at555 && d == 8'h90) st <= S_AUTO;
          else if (at555 && d == 8'h20) begin st <= S_BYP; ret_byp <= 1'b1; end
          else st <= S_READ;
        S_E1:   st <= (d == 8'hAA && at555) ? S_E2 : S_READ;
        S_E2:   st <= (d == 8'h55 && at2aa) ? S_E3 : S_READ;
        S_AUTO: if (d == 8'hF0) st <= S_READ;
        S_BYP:  if (d == 8'hA0) st <= S_BYPP; else if (d == 8'h90) st <= S_BYPX;
        S_BYPX:
          if (d == 8'h00) begin st <= S_READ; ret_byp <= 1'b0; end
          else st <= S_BYP;
        S_WBC:
          if (sa == wsect && wdata[15:4] == 12'h0) begin
            last <= wdata[3:0]; wb_i <= '0; st <= S_WBD;
          end else st <= S_READ;
        S_WBD:
          if (sa != wsect) st <= S_READ;
          else if (wb_i == last) st <= S_WBF;
          else wb_i <= wb_i + 1'b1;
        default: st <= S_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      tog <= 1'b0;
    end else if (rd_en) begin
      if (st == S_BUSY) begin
        rdata <= {8'h00, is_er ? 1'b0 : ~buf_d[last][7], tog, 6'h00};
        tog <= ~tog;
      end else if (st == S_AUTO) begin
        case (addr[1:0])
          2'd0: rdata <= {8'h00, MFR_ID};
          2'd1: rdata <= {8'h00, DEV_ID};
          2'd2: rdata <= {15'h0, prot_v[sa]};
          default: rdata <= '0;
        endcase
      end else rdata <= mem[addr];
    end
  end

  a_r3_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(wr_en));
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && cnt != endc) |=> !rdy);
  a_r8_veto_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && blocked) |=> rdy);
  a_r9_unlock_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_U1 && wr_en && !(d == 8'h55 && at2aa)) |=> st == S_READ);
  a_r5_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WBD) |-> wb_i <= last);
  a_r6_erase_span: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && is_er) |-> cnt < CNT_W'(SECT_WORDS));
endmodule

// File: tb/sim_flash_cmd_fsm.sv
module sim_flash_cmd_fsm;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, wp_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] lock = '0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rdy;
  int checks = 0, fails = 0;
  logic [15:0] q_exp[$];
  logic [15:0] q_msk[$];
  string q_tag[$];
  logic q_en = 1'b0, pend = 1'b0;
  logic [15:0] s1, s2;
  int n;

  flash_cmd_fsm u0 (.clk(clk), .rst_n(rst_n), .wp_n(wp_n), .sect_lock(lock), .wr_en(wr_en),
                    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy));

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unl();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic rd_chk(input logic [10:0] a, input logic [15:0] e, input string tag,
                        input logic [15:0] m = 16'hFFFF);
    rd_en = 1'b1; q_en = 1'b1; addr = a;
    q_exp.push_back(e); q_msk.push_back(m); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; q_en = 1'b0;
  endtask

  task automatic rd_raw(input logic [10:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic wait_rdy(output int cnt);
    cnt = 0;
    while (!rdy && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) pend <= q_en;

  always @(negedge clk) begin
    if (pend && q_exp.size() > 0) begin
      logic [15:0] e, m;
      string t;
      e = q_exp.pop_front(); m = q_msk.pop_front(); t = q_tag.pop_front();
      check((rdata & m) == (e & m), t, rdata & m, e & m);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(rdy == 1'b1, "R1 rdy after reset", 16'(rdy), 16'h1);
    rd_chk(11'h010, 16'hFFFF, "R1 erased read");

    // R2 / R3 four-cycle program, status and busy length
    unl(); wr(11'h555, 16'h00A0); wr(11'h123, 16'h5A3C);
    check(rdy == 1'b0, "R3 busy starts", 16'(rdy), 16'h0);
    rd_raw(11'h123, s1);
    rd_raw(11'h123, s2);
    check((s1 & 16'hFFBF) == 16'h0080, "R3 status dq7", s1 & 16'hFFBF, 16'h0080);
    check(s1[6] != s2[6], "R3 dq6 toggle", 16'(s2[6]), 16'(~s1[6]));
    wait_rdy(n);
    check(n + 2 == 20, "R3 busy length", 16'(n + 2), 16'd20);
    rd_chk(11'h123, 16'h5A3C, "R2 programmed word");

    // R9 broken unlock sequences
    unl(); wr(11'h555, 16'h0012); wr(11'h200, 16'hABCD);
    check(rdy == 1'b1, "R9 no busy after abort", 16'(rdy), 16'h1);
    rd_chk(11'h200, 16'hFFFF, "R9 bad command ignored");
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h201, 16'h1234);
    rd_chk(11'h201, 16'hFFFF, "R9 bad second cycle");

    // R4 bypass mode
    unl(); wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0); wr(11'h050, 16'h1111); wait_rdy(n);
    wr(11'h000, 16'h00A0); wr(11'h051, 16'h2222); wait_rdy(n);
    rd_chk(11'h050, 16'h1111, "R4 bypass program 1");
    rd_chk(11'h051, 16'h2222, "R4 bypass program 2");
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0); wr(11'h052, 16'h3333);
    check(rdy == 1'b1, "R4 exit bypass no busy", 16'(rdy), 16'h1);
    rd_chk(11'h052, 16'hFFFF, "R4 after exit");

    // R5 buffered program
    unl(); wr(11'h200, 16'h0025); wr(11'h200, 16'h0003);
    for (int i = 0; i < 4; i++) wr(11'h210 + 11'(i), (i == 3) ? 16'h00A5 : 16'h1000 + 16'(i));
    wr(11'h200, 16'h0029);
    rd_raw(11'h200, s1);
    check((s1 & 16'hFFBF) == 16'h0000, "R3 buffer status dq7", s1 & 16'hFFBF, 16'h0000);
    wait_rdy(n);
    rd_chk(11'h210, 16'h1000, "R5 buffer word 0");
    rd_chk(11'h212, 16'h1002, "R5 buffer word 2");
    rd_chk(11'h213, 16'h00A5, "R5 buffer word 3");
    unl(); wr(11'h200, 16'h0025); wr(11'h200, 16'h000F);
    for (int i = 0; i < 16; i++) wr(11'h220 + 11'(i), 16'h2000 + 16'(i));
    wr(11'h200, 16'h0029); wait_rdy(n);
    rd_chk(11'h220, 16'h2000, "R5 full buffer first");
    rd_chk(11'h22F, 16'h200F, "R5 full buffer last");
    unl(); wr(11'h200, 16'h0025); wr(11'h200, 16'h0010); wr(11'h240, 16'h7777);
    check(rdy == 1'b1, "R5 oversize count aborts", 16'(rdy), 16'h1);
    rd_chk(11'h240, 16'hFFFF, "R5 oversize no write");

    // R6 sector erase
    unl(); wr(11'h555, 16'h0080); unl(); wr(11'h200, 16'h0030);
    rd_raw(11'h200, s1);
    check((s1 & 16'hFFBF) == 16'h0000, "R3 erase status", s1 & 16'hFFBF, 16'h0000);
    wait_rdy(n);
    check(n + 1 == 256, "R6 erase length", 16'(n + 1), 16'd256);
    rd_chk(11'h210, 16'hFFFF, "R6 erased word");
    rd_chk(11'h22F, 16'hFFFF, "R6 erased word end");
    rd_chk(11'h123, 16'h5A3C, "R6 other sector kept");

    // R7 identifier mode
    unl(); wr(11'h555, 16'h0090);
    rd_chk(11'h000, 16'h0001, "R7 manufacturer");
    rd_chk(11'h001, 16'h007E, "R7 device");
    rd_chk(11'h102, 16'h0000, "R7 unprotected");
    lock = 8'h20;
    rd_chk(11'h502, 16'h0001, "R7 protected");
    wr(11'h000, 16'h00F0);
    rd_chk(11'h123, 16'h5A3C, "R7 back to array");

    // R8 protection
    unl(); wr(11'h555, 16'h00A0); wr(11'h510, 16'h0F0F);
    check(rdy == 1'b0, "R8 brief busy", 16'(rdy), 16'h0);
    @(negedge clk);
    check(rdy == 1'b1, "R8 busy one cycle", 16'(rdy), 16'h1);
    rd_chk(11'h510, 16'hFFFF, "R8 locked sector unchanged");
    unl(); wr(11'h555, 16'h0080); unl(); wr(11'h500, 16'h0030); wait_rdy(n);
    check(n == 1, "R8 locked erase brief", 16'(n), 16'h1);
    wp_n = 1'b0;
    unl(); wr(11'h555, 16'h00A0); wr(11'h7F0, 16'h0B0B); wait_rdy(n);
    rd_chk(11'h7F0, 16'hFFFF, "R8 wp last sector");
    wp_n = 1'b1;
    unl(); wr(11'h555, 16'h00A0); wr(11'h7F0, 16'h0B0B); wait_rdy(n);
    rd_chk(11'h7F0, 16'h0B0B, "R8 wp released");

    // R10 reset aborts and ignores writes
    unl(); wr(11'h555, 16'h0080); unl(); wr(11'h300, 16'h0030);
    repeat (5) @(negedge clk);
    check(rdy == 1'b0, "R10 erase running", 16'(rdy), 16'h0);
    rst_n = 1'b0;
    unl(); wr(11'h555, 16'h00A0);
    rst_n = 1'b1;
    check(rdy == 1'b1, "R10 rdy after reset", 16'(rdy), 16'h1);
    wr(11'h060, 16'h4444);
    check(rdy == 1'b1, "R10 writes in reset ignored", 16'(rdy), 16'h1);
    rd_chk(11'h060, 16'hFFFF, "R10 array untouched");
    rd_chk(11'h123, 16'h5A3C, "R10 array reads");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule